// File: doc/BRIEF.md
# USB Full/Low-Speed Line Decoder

This block watches the two raw data lines of a full-speed or low-speed USB link. It samples them with a clock that runs a fixed number of times faster than the bit rate, and turns them into a stream of line events. Each line sample is classified into one of four line states: idle-polarity (J), opposite polarity (K), both low (SE0) and both high (SE1). A mode input picks which differential polarity counts as idle. A bit timer locks to the centre of each bit cell again at every symbol change.

The decoder reverses NRZI coding, drops the zero that the transmitter inserts after a run of six ones, and frames packets. A packet opens when the idle line first swings to K and closes on the SE0-then-J end sequence. Events leave the block as a single-cycle strobe that carries a two-bit kind code and a data bit. Packet-field parsing, checksums, the analog receiver and bus reset or resume detection are left to other blocks.

Top module: `usb_line_decoder`

## Requirements
- R1: With low_speed=0, {dp,dm}=2'b10 is J and 2'b01 is K. With low_speed=1 the two are swapped. 2'b00 is SE0 and 2'b11 is SE1 in both modes.
- R2: After reset, evt_valid stays 0 while the line rests in J, and the NRZI reference symbol is J.
- R3: While idle, a line change from J to K produces one event of kind 0 (start of packet) with evt_bit=0. It appears SYNC_STAGES+2 clocks after the change is first presented at the pins.
- R4: A symbol is sampled OSR/2 samples after each line change and then every OSR samples. Its data event appears SYNC_STAGES+OSR/2+2 clocks after the change that began the bit, and lasts a single cycle.
- R5: Inside a packet, each J or K sample gives one event of kind 1 (data). evt_bit is 1 when the sample equals the previous J/K sample and 0 when it differs. The first sample after the start is compared against J.
- R6: A decoded 0 that follows exactly six consecutive decoded ones is reported as kind 2 (stuff bit, evt_bit=0), is not reported as data, and clears the run count.
- R7: A decoded 0 that follows seven or more consecutive ones is reported as an ordinary data event (kind 1, evt_bit=0).
- R8: SE0 and SE1 samples inside a packet produce no event and do not move the NRZI reference.
- R9: A J sample directly after an SE0 sample produces kind 3 (end of packet, evt_bit=0) and no data event, and the decoder returns to idle.
- R10: While idle, sampled symbols and line changes other than J to K produce no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OSR samples per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp | input | 1 | Raw positive data line |
| dm | input | 1 | Raw negative data line |
| low_speed | input | 1 | 1 selects low-speed polarity, 0 full-speed |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_kind | output | 2 | 0 start, 1 data, 2 stuff, 3 end of packet |
| evt_bit | output | 1 | Decoded bit for data events, 0 otherwise |

## Verification
A line change reaches the classified symbol after SYNC_STAGES+1 rising edges. So a start event is due SYNC_STAGES+2 clocks after the change is driven, and the first data event of a bit OSR/2 clocks after that, with later bits every OSR clocks. The bench drives the lines on falling edges and samples the outputs there too. It stamps every event with the count of rising edges and compares the stamps of the first packet against those exact offsets. Event order, kinds and bits are compared as whole sequences only after each packet has fully drained.

// File: rtl/usbld_pkg.sv
package usbld_pkg;

   typedef enum logic [1:0] {
      SYM_SE0 = 2'd0,
      SYM_J   = 2'd1,
      SYM_K   = 2'd2,
      SYM_SE1 = 2'd3
   } line_sym_t;

   typedef enum logic [1:0] {
      EV_SOP   = 2'd0,
      EV_BIT   = 2'd1,
      EV_STUFF = 2'd2,
      EV_EOP   = 2'd3
   } evt_kind_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_PKT  = 1'b1
   } dec_state_t;

   localparam int unsigned STUFF_RUN = 6;
   localparam int unsigned RUN_W     = 3;

endpackage

// File: rtl/usbld_line_class.sv
module usbld_line_class
   import usbld_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      dp,
   input  logic      dm,
   input  logic      low_speed,
   output line_sym_t sym_q
);

   logic [1:0] lines;
   line_sym_t  sym_d;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign lines = {dp, dm};
      end else begin : g_sync
         logic [1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 2'b00;
            end else begin
               stg[0] <= {dp, dm};
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign lines = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      unique case (lines)
         2'b00:   sym_d = SYM_SE0;
         2'b11:   sym_d = SYM_SE1;
         2'b10:   sym_d = low_speed ? SYM_K : SYM_J;
         default: sym_d = low_speed ? SYM_J : SYM_K;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sym_q <= SYM_J;
      else        sym_q <= sym_d;
   end

endmodule

// File: rtl/usbld_bit_timer.sv
module usbld_bit_timer
   import usbld_pkg::*;
#(
   parameter int unsigned OSR = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_sym_t sym,
   output logic      chg,
   output logic      strobe,
   output line_sym_t prev_sym
);

   localparam int unsigned CW = $clog2(OSR);
   localparam logic [CW-1:0] HALF_C = CW'(OSR / 2);
   localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
   localparam logic [CW-1:0] ONE_C  = CW'(1);

   logic [CW-1:0] phase;

   assign chg    = (sym != prev_sym);
   assign strobe = !chg && (phase == HALF_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         prev_sym <= SYM_J;
      end else begin
         prev_sym <= sym;
         if (chg)                  phase <= ONE_C;
         else if (phase == LAST_C) phase <= '0;
         else                      phase <= phase + ONE_C;
      end
   end

endmodule

// File: rtl/usbld_unstuff_fsm.sv
module usbld_unstuff_fsm
   import usbld_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  line_sym_t  sym,
   input  line_sym_t  prev_sym,
   input  logic       chg,
   input  logic       strobe,
   output logic       evt_valid,
   output logic [1:0] evt_kind,
   output logic       evt_bit,
   output dec_state_t state
);

   localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(STUFF_RUN);
   localparam logic [RUN_W-1:0] RUN_MAX   = '1;

   line_sym_t        nrzi_ref;
   line_sym_t        last_samp;
   logic [RUN_W-1:0] ones;
   logic             is_level;
   logic             dec_bit;

   assign is_level = (sym == SYM_J) || (sym == SYM_K);
   assign dec_bit  = (sym == nrzi_ref);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         nrzi_ref  <= SYM_J;
         last_samp <= SYM_J;
         ones      <= '0;
         evt_valid <= 1'b0;
         evt_kind  <= EV_SOP;
         evt_bit   <= 1'b0;
      end else begin
         evt_valid <= 1'b0;
         evt_bit   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (chg && prev_sym == SYM_J && sym == SYM_K) begin
                  evt_valid <= 1'b1;
                  evt_kind  <= EV_SOP;
                  state     <= ST_PKT;
                  nrzi_ref  <= SYM_J;
                  last_samp <= SYM_J;
                  ones      <= '0;
               end
            end
            ST_PKT: begin
               if (strobe) begin
                  last_samp <= sym;
                  if (sym == SYM_J && last_samp == SYM_SE0) begin
                     evt_valid <= 1'b1;
                     evt_kind  <= EV_EOP;
                     state     <= ST_IDLE;
                     nrzi_ref  <= SYM_J;
                     ones      <= '0;
                  end else if (is_level) begin
                     nrzi_ref  <= sym;
                     evt_valid <= 1'b1;
                     if (ones == RUN_LIMIT && !dec_bit) begin
                        evt_kind <= EV_STUFF;
                        ones     <= '0;
                     end else begin
                        evt_kind <= EV_BIT;
                        evt_bit  <= dec_bit;
                        if (!dec_bit)            ones <= '0;
                        else if (ones != RUN_MAX) ones <= ones + 1'b1;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/usb_line_decoder.sv
module usb_line_decoder
   import usbld_pkg::*;
#(
   parameter int unsigned OSR         = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dp,
   input  logic       dm,
   input  logic       low_speed,
   output logic       evt_valid,
   output logic [1:0] evt_kind,
   output logic       evt_bit
);

   generate
      if (OSR < 4) begin : g_bad_osr
         $error("usb_line_decoder: OSR must be at least 4");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("usb_line_decoder: SYNC_STAGES must not exceed 4");
      end
   endgenerate

   line_sym_t  line_sym;
   line_sym_t  prev_line;
   logic       bit_chg;
   logic       bit_strobe;
   dec_state_t dec_state;

   usbld_line_class #(.SYNC_STAGES(SYNC_STAGES)) u_class (
      .clk       (clk),
      .rst_n     (rst_n),
      .dp        (dp),
      .dm        (dm),
      .low_speed (low_speed),
      .sym_q     (line_sym)
   );

   usbld_bit_timer #(.OSR(OSR)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym      (line_sym),
      .chg      (bit_chg),
      .strobe   (bit_strobe),
      .prev_sym (prev_line)
   );

   usbld_unstuff_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym       (line_sym),
      .prev_sym  (prev_line),
      .chg       (bit_chg),
      .strobe    (bit_strobe),
      .evt_valid (evt_valid),
      .evt_kind  (evt_kind),
      .evt_bit   (evt_bit),
      .state     (dec_state)
   );

endmodule

// File: rtl/usbld_checker.sv
module usbld_checker
   import usbld_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       evt_valid,
   input logic [1:0] evt_kind,
   input logic       evt_bit,
   input logic       strobe,
   input dec_state_t dec_state
);

   // R3: a start event always coincides with entering the packet state
   a_r3_sop_enters_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_kind == EV_SOP) |-> (dec_state == ST_PKT));

   // R4: data and stuff events come from a bit-centre sample
   a_r4_data_at_centre: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_kind == EV_BIT || evt_kind == EV_STUFF)) |-> $past(strobe));

   // R4: a data or stuff event lasts a single cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_kind == EV_BIT || evt_kind == EV_STUFF)) |=> !evt_valid);

   // R6: a removed stuff bit carries a zero
   a_r6_stuff_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_kind == EV_STUFF) |-> !evt_bit);

   // R9: the end event returns the decoder to idle
   a_r9_eop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_kind == EV_EOP) |-> (dec_state == ST_IDLE));

   // R10: while idle, only the closing end event may be seen
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && dec_state == ST_IDLE) |-> (evt_kind == EV_EOP));

endmodule

bind usb_line_decoder usbld_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_kind  (evt_kind),
   .evt_bit   (evt_bit),
   .strobe    (bit_strobe),
   .dec_state (dec_state)
);

// File: tb/usb_line_decoder_test.sv
module usb_line_decoder_test;
   import usbld_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int OSR        = 8;
   localparam int SYNC       = 2;
   localparam int HALF       = OSR / 2;
   localparam int LAT        = SYNC + 2;
   localparam int NVEC       = 8;

   // {low_speed, payload (sent LSB first), expected stuff count}
   localparam logic [18:0] VEC [NVEC] = '{
      {1'b0, 16'h0000, 2'd0},
      {1'b0, 16'hFFFF, 2'd2},
      {1'b1, 16'hFFFF, 2'd2},
      {1'b0, 16'h00FF, 2'd1},
      {1'b1, 16'h0F0F, 2'd0},
      {1'b0, 16'h7E00, 2'd1},
      {1'b1, 16'h3F00, 2'd1},
      {1'b0, 16'h1F00, 2'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dp = 1'b1;
   logic dm = 1'b0;
   logic ls = 1'b0;
   logic       evt_valid;
   logic [1:0] evt_kind;
   logic       evt_bit;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_line_decoder #(.OSR(OSR), .SYNC_STAGES(SYNC)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dp        (dp),
      .dm        (dm),
      .low_speed (ls),
      .evt_valid (evt_valid),
      .evt_kind  (evt_kind),
      .evt_bit   (evt_bit)
   );

   int checks = 0;
   int errors = 0;
   int pcnt = 0;
   int act_k[$], act_b[$], act_t[$];
   int exp_k[$], exp_b[$];
   line_sym_t tx_lvl = SYM_J;
   int tx_ones = 0;
   int drv_t0 = 0;

   always @(posedge clk) pcnt++;

   always @(negedge clk) begin
      if (rst_n && evt_valid) begin
         act_k.push_back(int'(evt_kind));
         act_b.push_back(int'(evt_bit));
         act_t.push_back(pcnt);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put_sym(input line_sym_t s);
      case (s)
         SYM_SE0: {dp, dm} = 2'b00;
         SYM_SE1: {dp, dm} = 2'b11;
         SYM_J:   {dp, dm} = ls ? 2'b01 : 2'b10;
         default: {dp, dm} = ls ? 2'b10 : 2'b01;
      endcase
      repeat (OSR) @(negedge clk);
   endtask

   task automatic put_bit(input bit b);
      if (!b) tx_lvl = (tx_lvl == SYM_J) ? SYM_K : SYM_J;
      put_sym(tx_lvl);
   endtask

   task automatic data_bit(input bit b, input bit stuffing);
      put_bit(b);
      exp_k.push_back(1);
      exp_b.push_back(int'(b));
      tx_ones = b ? tx_ones + 1 : 0;
      if (stuffing && tx_ones == 6) begin
         put_bit(1'b0);
         exp_k.push_back(2);
         exp_b.push_back(0);
         tx_ones = 0;
      end
   endtask

   task automatic start_pkt();
      act_k.delete(); act_b.delete(); act_t.delete();
      exp_k.delete(); exp_b.delete();
      tx_lvl = SYM_J;
      tx_ones = 0;
      exp_k.push_back(0);
      exp_b.push_back(0);
      drv_t0 = pcnt;
      for (int i = 0; i < 7; i++) data_bit(1'b0, 1'b1);
      data_bit(1'b1, 1'b1);
   endtask

   task automatic end_pkt();
      put_sym(SYM_SE0);
      put_sym(SYM_SE0);
      tx_lvl = SYM_J;
      put_sym(SYM_J);
      exp_k.push_back(3);
      exp_b.push_back(0);
      put_sym(SYM_J);
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic set_mode(input bit m);
      put_sym(SYM_SE0);
      ls = m;
      put_sym(SYM_J);
      put_sym(SYM_J);
   endtask

   task automatic cmp_seq(input string req);
      int mism;
      chk(act_k.size() == exp_k.size(), {req, " event count"}, act_k.size(), exp_k.size());
      if (act_k.size() == exp_k.size()) begin
         mism = -1;
         for (int i = 0; i < exp_k.size(); i++) begin
            if (mism < 0 && (act_k[i] != exp_k[i] || act_b[i] != exp_b[i])) mism = i;
         end
         chk(mism < 0, {req, " event kind*2+bit at first mismatch"},
             (mism < 0) ? 0 : act_k[mism] * 2 + act_b[mism],
             (mism < 0) ? 0 : exp_k[mism] * 2 + exp_b[mism]);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", pcnt, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(evt_valid == 1'b0, "R2 valid during reset", int'(evt_valid), 0);
      rst_n = 1'b1;
      repeat (4 * OSR) @(negedge clk);
      chk(act_k.size() == 0, "R2 no event after reset on idle J", act_k.size(), 0);

      // table of packets
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] pay;
         logic [15:0] got;
         int nstuff, nb;
         pay = VEC[v][17:2];
         if (VEC[v][18] != ls) set_mode(VEC[v][18]);
         start_pkt();
         for (int i = 0; i < 16; i++) data_bit(pay[i], 1'b1);
         end_pkt();
         cmp_seq(VEC[v][18] ? "R1/R5/R6/R9 low-speed" : "R5/R6/R9 full-speed");
         nstuff = 0;
         foreach (act_k[i]) if (act_k[i] == 2) nstuff++;
         chk(nstuff == int'(VEC[v][1:0]), "R6 stuff count", nstuff, int'(VEC[v][1:0]));
         got = '0;
         nb = 0;
         foreach (act_k[i]) begin
            if (act_k[i] == 1) begin
               if (nb >= 8 && nb < 24) got[nb-8] = act_b[i][0];
               nb++;
            end
         end
         chk(got == pay, "R5 payload bits", int'(got), int'(pay));
         if (v == 0) begin
            chk(act_t.size() > 2, "R3 event stamps present", act_t.size(), 3);
            if (act_t.size() > 2) begin
               chk(act_t[0] == drv_t0 + LAT, "R3 start latency", act_t[0], drv_t0 + LAT);
               chk(act_t[1] == drv_t0 + HALF + LAT, "R4 first bit latency",
                   act_t[1], drv_t0 + HALF + LAT);
               chk(act_t[2] == drv_t0 + OSR + HALF + LAT, "R4 bit period",
                   act_t[2], drv_t0 + OSR + HALF + LAT);
            end
         end
      end

      // R7: eight ones in a row (no stuffing), then a zero is ordinary data
      set_mode(1'b0);
      start_pkt();
      for (int i = 0; i < 7; i++) data_bit(1'b1, 1'b0);
      data_bit(1'b0, 1'b0);
      end_pkt();
      cmp_seq("R7 long run then zero");

      // R8: SE1 inside a packet gives no event and leaves the reference alone
      start_pkt();
      put_sym(SYM_SE1);
      data_bit(1'b0, 1'b1);
      end_pkt();
      cmp_seq("R8 SE1 inside packet");

      // R10: idle line with SE1, SE0 and J gives no events
      act_k.delete(); act_b.delete(); act_t.delete();
      put_sym(SYM_SE1);
      put_sym(SYM_J);
      put_sym(SYM_SE0);
      put_sym(SYM_J);
      put_sym(SYM_J);
      repeat (LAT + 2) @(negedge clk);
      chk(act_k.size() == 0, "R10 idle quiet", act_k.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule